// File: doc/BRIEF.md
# Nearest-Centroid Assignment Unit

This block is a single map worker for one iteration of k-means clustering. Before an iteration begins, the K cluster centres of the previous iteration (each with D signed fixed-point coordinates) are written word by word into the worker's own private storage. Once every word has been written, the worker starts pulling points from a shared valid/ready input stream. It takes a point only when it has nothing else in hand, so several workers can share one input buffer.

For each point the worker walks the stored centres one by one, one coordinate per cycle. It accumulates the squared coordinate differences and keeps the smallest total seen so far. After the last centre it presents a key/value pair on a valid/ready output. The key is the index of the nearest centre. The value is the point exactly as it arrived. The pair stays put until the consumer takes it, and only then does the worker ask for a new point.

Top module: `kmap_nearest`

## Requirements
- R1: After reset `loaded` is 0 and `in_ready` is 0. `loaded` goes to 1 once every one of the K*D storage words has been written at least once, and it then stays 1.
- R2: A storage write places `ld_data` at word `ld_addr = k*D + d`, which is coordinate d of centre k. A write issued from the cycle after a point is accepted until its pair has been taken is ignored, and the stored centres keep their values.
- R3: `in_ready` is 1 exactly when the unit is loaded and holds no point. A point is accepted on a clock edge where `in_valid` and `in_ready` are both 1.
- R4: `out_key` is the index k that minimises the sum over all D coordinates of (point[d] - centre[k][d])^2. Coordinates are two's-complement CW-bit values, packed with coordinate d at bits [d*CW +: CW].
- R5: When several centres are at the same minimum distance, the lowest index among them is the key.
- R6: `out_point` equals the accepted `in_point`, bit for bit.
- R7: `out_valid` rises on the K*D-th clock edge after the accepting edge. There is exactly one output pair per accepted point.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_key` and `out_point` hold their values and `in_ready` stays 0. The pair is released on the edge where `out_ready` is 1.
- R9: Distances are exact over the full coordinate range. With all coordinates at -2^(CW-1) or 2^(CW-1)-1, the nearest centre is still chosen correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Centre storage write strobe |
| ld_addr | input | AW | Storage word index, k*D + d |
| ld_data | input | CW | Signed coordinate to store |
| loaded | output | 1 | All K*D words have been written |
| in_valid | input | 1 | Input point offered |
| in_ready | output | 1 | Unit will take a point this cycle |
| in_point | input | D*CW | Input point, coordinate d at [d*CW +: CW] |
| out_valid | output | 1 | Key/value pair available |
| out_ready | input | 1 | Consumer takes the pair |
| out_key | output | KW | Index of the nearest centre |
| out_point | output | D*CW | The point, unchanged |

## Verification
The bench aims at ties: duplicated centres, and centres placed symmetrically about a point. A design that kept the last winner instead of the first would report the higher index there. It writes the storage while a point is being processed and then sends a point whose answer depends on whether that write took effect. A design that did not block the write would give the wrong key on the second point. It places centres and points at the extreme coordinates, where a narrow accumulator would wrap and pick a far centre. It also holds `out_ready` low while offering a further point. A design that dropped or changed the pair, or accepted the new point early, shows up as a changed output or a raised `in_ready`.

// File: rtl/kmap_pkg.sv
package kmap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_OUT  = 2'd2
    } kmap_state_e;
endpackage

// File: rtl/kmap_sqdiff.sv
module kmap_sqdiff #(
    parameter int CW  = 8,
    parameter int SQW = 2 * CW + 2
) (
    input  logic [CW-1:0]  a_i,
    input  logic [CW-1:0]  b_i,
    output logic [SQW-1:0] sq_o
);
    logic signed [CW:0] diff;
    logic        [CW:0] mag;

    always_comb begin
        diff = $signed({a_i[CW-1], a_i}) - $signed({b_i[CW-1], b_i});
        mag  = diff[CW] ? (~diff + 1'b1) : diff;
        sq_o = {{(SQW - 2*CW - 2){1'b0}}, mag} * {{(SQW - 2*CW - 2){1'b0}}, mag};
    end
endmodule

// File: rtl/kmap_cent_store.sv
module kmap_cent_store #(
    parameter int K  = 4,
    parameter int D  = 3,
    parameter int CW = 8,
    parameter int KW = 2,
    parameter int DW = 2,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          lock_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] data_i,
    input  logic [KW-1:0] rd_k_i,
    input  logic [DW-1:0] rd_d_i,
    output logic [CW-1:0] rd_o,
    output logic          full_o
);
    localparam int NW = K * D;

    logic [NW*CW-1:0] mem_d, mem_q;
    logic [NW-1:0]    seen_d, seen_q;

    always_comb begin
        mem_d  = mem_q;
        seen_d = seen_q;
        if (we_i && !lock_i && (int'(addr_i) < NW)) begin
            mem_d[int'(addr_i)*CW +: CW] = data_i;
            seen_d[int'(addr_i)]         = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q  <= '0;
            seen_q <= '0;
        end else begin
            mem_q  <= mem_d;
            seen_q <= seen_d;
        end
    end

    assign rd_o   = mem_q[(int'(rd_k_i)*D + int'(rd_d_i))*CW +: CW];
    assign full_o = &seen_q;

    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && lock_i) |=> $stable(mem_q)); // R2
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> full_o); // R1
endmodule

// File: rtl/kmap_nearest.sv
module kmap_nearest #(
    parameter int K  = 4,
    parameter int D  = 3,
    parameter int CW = 8,
    localparam int KW   = (K > 1) ? $clog2(K) : 1,
    localparam int DW   = (D > 1) ? $clog2(D) : 1,
    localparam int NW   = K * D,
    localparam int AW   = (NW > 1) ? $clog2(NW) : 1,
    localparam int PW   = D * CW,
    localparam int SQW  = 2 * CW + 2,
    localparam int ACCW = SQW + ((D > 1) ? $clog2(D) : 0)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_data,
    output logic          loaded,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [PW-1:0] in_point,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [KW-1:0] out_key,
    output logic [PW-1:0] out_point
);
    import kmap_pkg::*;

    typedef struct packed {
        kmap_state_e     st;
        logic [KW-1:0]   k;
        logic [DW-1:0]   d;
        logic [ACCW-1:0] acc;
        logic [ACCW-1:0] best;
        logic [KW-1:0]   key;
        logic [PW-1:0]   pt;
    } work_t;

    work_t r_d, r_q;

    logic [CW-1:0]   cent_w;
    logic [CW-1:0]   coord_w;
    logic [SQW-1:0]  sq_w;
    logic [ACCW-1:0] sum_w;
    logic            full_w;

    kmap_cent_store #(
        .K(K), .D(D), .CW(CW), .KW(KW), .DW(DW), .AW(AW)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (ld_we),
        .lock_i (r_q.st != ST_IDLE),
        .addr_i (ld_addr),
        .data_i (ld_data),
        .rd_k_i (r_q.k),
        .rd_d_i (r_q.d),
        .rd_o   (cent_w),
        .full_o (full_w)
    );

    assign coord_w = r_q.pt[int'(r_q.d)*CW +: CW];

    kmap_sqdiff #(.CW(CW), .SQW(SQW)) u_sq (
        .a_i  (coord_w),
        .b_i  (cent_w),
        .sq_o (sq_w)
    );

    always_comb begin
        r_d   = r_q;
        sum_w = ((r_q.d == '0) ? '0 : r_q.acc) + {{(ACCW-SQW){1'b0}}, sq_w};
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid && full_w) begin
                    r_d.st = ST_RUN;
                    r_d.k  = '0;
                    r_d.d  = '0;
                    r_d.pt = in_point;
                end
            end
            ST_RUN: begin
                r_d.acc = sum_w;
                if (r_q.d == DW'(D - 1)) begin
                    r_d.d = '0;
                    if ((r_q.k == '0) || (sum_w < r_q.best)) begin
                        r_d.best = sum_w;
                        r_d.key  = r_q.k;
                    end
                    if (r_q.k == KW'(K - 1)) begin
                        r_d.st = ST_OUT;
                    end else begin
                        r_d.k = r_q.k + 1'b1;
                    end
                end else begin
                    r_d.d = r_q.d + 1'b1;
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign loaded    = full_w;
    assign in_ready  = (r_q.st == ST_IDLE) && full_w;
    assign out_valid = (r_q.st == ST_OUT);
    assign out_key   = r_q.key;
    assign out_point = r_q.pt;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_point))); // R8
    AST_NO_TAKE_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8
    AST_READY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> loaded); // R1
    AST_KEY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_key <= KW'(K - 1))); // R4
    AST_OUT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(r_q.st == ST_RUN)); // R7
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid)); // R3
endmodule

// File: tb/sim_kmap_nearest.sv
module sim_kmap_nearest;
    localparam int CLK_PERIOD = 10;
    localparam int K  = 4;
    localparam int D  = 3;
    localparam int CW = 8;
    localparam int KW = 2;
    localparam int AW = 4;
    localparam int PW = D * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [CW-1:0] ld_data = '0;
    logic          loaded;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_point = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [KW-1:0] out_key;
    logic [PW-1:0] out_point;

    int errors = 0;
    int checks = 0;
    int cent_m [K*D];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kmap_nearest #(.K(K), .D(D), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .loaded(loaded), .in_valid(in_valid), .in_ready(in_ready), .in_point(in_point),
        .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key), .out_point(out_point)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] pack(int p [D]);
        logic [PW-1:0] v;
        for (int d = 0; d < D; d++) v[d*CW +: CW] = p[d][CW-1:0];
        return v;
    endfunction

    function automatic int ref_key(int p [D]);
        int best = 0;
        int bd = -1;
        for (int k = 0; k < K; k++) begin
            int s = 0;
            for (int d = 0; d < D; d++) s += (p[d] - cent_m[k*D+d]) * (p[d] - cent_m[k*D+d]);
            if (bd < 0 || s < bd) begin bd = s; best = k; end
        end
        return best;
    endfunction

    function automatic int rnd_coord();
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic wr(int addr, int val);
        ld_we = 1'b1; ld_addr = AW'(addr); ld_data = val[CW-1:0];
        cent_m[addr] = val;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic load_all(int c [K*D]);
        for (int i = 0; i < K*D; i++) wr(i, c[i]);
    endtask

    // Sends one point; optionally writes storage mid-run (must be ignored).
    task automatic send(int p [D], string req, int hold, bit mid_wr, int wa, int wv);
        logic [PW-1:0] pv;
        int exp;
        pv = pack(p);
        exp = ref_key(p);
        in_valid = 1'b1; in_point = pv;
        check("R3 in_ready when idle", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        for (int j = 1; j < K*D; j++) begin
            if (mid_wr && j == 1) begin ld_we = 1'b1; ld_addr = AW'(wa); ld_data = wv[CW-1:0]; end
            @(negedge clk);
            ld_we = 1'b0;
        end
        check("R7 no early out_valid", int'(out_valid), 0);
        @(negedge clk);
        check("R7 out_valid at K*D", int'(out_valid), 1);
        check(req, int'(out_key), exp);
        check("R6 point passed through", int'(out_point == pv), 1);
        for (int h = 0; h < hold; h++) begin
            in_valid = 1'b1; in_point = ~pv;
            @(negedge clk);
            check("R8 held key", int'(out_key), exp);
            check("R8 held valid and point", int'(out_valid && out_point == pv), 1);
            check("R8 no accept while holding", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R8 released after take", int'(out_valid), 0);
    endtask

    initial begin
        int c [K*D];
        int p [D];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 loaded after reset", int'(loaded), 0);
        check("R1 in_ready after reset", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready before load", int'(in_ready), 0);
        // centres: c0=(0,0,0) c1=(10,10,10) c2=(-20,5,0) c3=(10,10,10)
        c = '{0,0,0, 10,10,10, -20,5,0, 10,10,10};
        for (int i = 0; i < K*D-1; i++) wr(i, c[i]);
        check("R1 not loaded with one word missing", int'(loaded), 0);
        wr(K*D-1, c[K*D-1]);
        check("R1 loaded when full", int'(loaded), 1);
        check("R3 in_ready once loaded", int'(in_ready), 1);

        p = '{9,9,9};   send(p, "R5 tie c1/c3 lower index", 2, 0, 0, 0);
        p = '{5,5,5};   send(p, "R5 tie c0/c1 lower index", 0, 0, 0, 0);
        p = '{-19,4,1}; send(p, "R4 directed nearest", 1, 0, 0, 0);
        // R2: a write to c0.x during a run must be ignored
        p = '{0,0,0};   send(p, "R2 point during blocked write", 0, 1, 0, 100);
        p = '{1,0,0};   send(p, "R2 centre unchanged after blocked write", 0, 0, 0, 0);

        // R9 extreme coordinates
        c = '{127,127,127, -128,-128,-128, -128,127,-128, 127,-128,127};
        load_all(c);
        p = '{-128,-128,127}; send(p, "R9 extreme tie", 0, 0, 0, 0);
        p = '{127,127,-128};  send(p, "R9 extreme tie 2", 1, 0, 0, 0);
        p = '{-128,127,127};  send(p, "R9 extreme far", 0, 0, 0, 0);
        for (int n = 0; n < 10; n++) begin
            for (int d = 0; d < D; d++) p[d] = ($urandom_range(1) != 0) ? 127 : -128;
            send(p, "R9 extreme random", 0, 0, 0, 0);
        end

        // random rounds
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < K*D; i++) c[i] = rnd_coord();
            load_all(c);
            for (int n = 0; n < 15; n++) begin
                for (int d = 0; d < D; d++) p[d] = rnd_coord();
                send(p, "R4 random nearest", int'($urandom_range(3)), 0, 0, 0);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule